// File: doc/BRIEF.md
# Multi-Environment Enabled-Instruction Sequencer

This block chooses, one at a time, the instructions that a single stream of a dataflow machine is allowed to execute. Its program store is divided into equal environment blocks. Each block runs its own strictly sequential code under a private program counter. Beside every instruction slot sits an operand-presence bit. A matching-store port raises that bit once all of the slot's operands have arrived. An instruction may leave the store only when its own environment's counter points at it and its presence bit is set.

The sequencer hunts for an environment whose current instruction is ready. It copies that instruction into an output register and raises a valid flag. It does not look for more work until the executor acknowledges. A mode pin selects one of two search styles. The proportional search visits environments one clock at a time, starting just after the environment served last. The vectored search keeps a per-environment "fresh operands" flag and jumps straight to the lowest-numbered flagged environment through a priority encoder. When nothing can proceed, the block sleeps until the matching store writes again.

Program words are loaded through a write port before operands start to arrive. The number of environments (a power of two, 2 to 16) and the number of slots per environment (a power of two) are parameters.

Top module: `ens_sequencer`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is low, and nothing is issued until some operand-presence bit has been set.
- R2: A slot is issued only when it is the slot addressed by its environment's program counter and its presence bit is set. A slot whose operands arrive before the counter reaches it waits, and the slots of one environment issue strictly in ascending slot order.
- R3: While `out_valid` is high and `out_ack` is low, `out_valid`, `out_instr`, `out_env` and `out_slot` hold their values. `out_env`/`out_slot` name the issued slot, and `out_instr` is the word loaded there.
- R4: Issuing a slot consumes it: its presence bit is cleared and its environment's counter advances by one. No slot is issued twice, and the bench sees no issue that it did not expect.
- R5: Once an environment has issued its last slot (counter equal to the slot count), it issues nothing more. Later operand writes aimed at that environment have no visible effect.
- R6: Proportional mode (`mode_vec` = 0): the search starts at the environment after the one last served and wraps from the highest index to 0.
- R7: Proportional mode spends one clock per environment examined. After a handshake on environment L, an instruction ready in environment T raises `out_valid` ((T − L − 1) mod N) + 1 clocks after the handshake edge.
- R8: When a proportional sweep of all N environments finds nothing, the sequencer idles. A later operand write wakes it, and the newly enabled instruction is then issued.
- R9: Vectored mode (`mode_vec` = 1): an operand write sets the target environment's ready flag. The lowest-numbered flagged environment is examined, and if its instruction is enabled, `out_valid` rises one clock after the handshake edge.
- R10: In vectored mode a flagged environment whose current instruction is not enabled loses its flag without issuing. An environment keeps its flag across an issue only if its next slot already holds its operands, so a lower-numbered environment drains its run of ready slots before a higher one is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_vec | input | 1 | 0 = proportional search, 1 = vectored search |
| prog_we | input | 1 | Program-word write strobe |
| prog_env | input | log2(NUM_ENV) | Environment of the program word |
| prog_slot | input | log2(SLOTS) | Slot of the program word |
| prog_data | input | INSTR_W | Program word |
| ms_we | input | 1 | Matching-store strobe: all operands of a slot are present |
| ms_env | input | log2(NUM_ENV) | Environment of the enabled slot |
| ms_slot | input | log2(SLOTS) | Enabled slot |
| out_valid | output | 1 | An issued instruction is waiting in the output register |
| out_ack | input | 1 | Executor has taken the output register |
| out_instr | output | INSTR_W | Issued instruction word |
| out_env | output | log2(NUM_ENV) | Environment of the issued instruction |
| out_slot | output | log2(SLOTS) | Slot of the issued instruction |

## Verification
The assertions assume that `mode_vec` stays constant between resets. They also assume that no program word is rewritten while operands are being delivered, and that an operand write never targets the very slot being issued in the same clock. The bench resets before every change of mode, loads the whole program before any operand strobe, and only strobes slots that are at or ahead of their environment's counter or past its end. For ordering and latency checks, the bench holds `out_ack` low while it enables the competing slots, so the issue order does not depend on when strobes land relative to the search.

// File: rtl/ens_pkg.sv
package ens_pkg;
  localparam int unsigned ENV_LIMIT = 16;

  typedef enum logic [1:0] {
    ST_SCAN = 2'd0,
    ST_HOLD = 2'd1,
    ST_IDLE = 2'd2
  } seq_state_e;
endpackage

// File: rtl/ens_store.sv
module ens_store #(
  parameter int unsigned NUM_ENV = 4,
  parameter int unsigned SLOTS   = 8,
  parameter int unsigned INSTR_W = 16,
  parameter int unsigned ENV_W   = $clog2(NUM_ENV),
  parameter int unsigned SLOT_W  = $clog2(SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               prog_we,
  input  logic [ENV_W-1:0]   prog_env,
  input  logic [SLOT_W-1:0]  prog_slot,
  input  logic [INSTR_W-1:0] prog_data,
  input  logic               ms_we,
  input  logic [ENV_W-1:0]   ms_env,
  input  logic [SLOT_W-1:0]  ms_slot,
  input  logic               iss_valid,
  input  logic [ENV_W-1:0]   iss_env,
  input  logic [ENV_W-1:0]   sel_env,
  output logic [INSTR_W-1:0] sel_instr,
  output logic [SLOT_W-1:0]  sel_slot,
  output logic [NUM_ENV-1:0] env_en,
  output logic [NUM_ENV-1:0] env_next_en
);
  localparam int unsigned DEPTH = NUM_ENV * SLOTS;
  localparam int unsigned PC_W  = SLOT_W + 1;

  logic [INSTR_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]   shd_q, shd_d;
  logic [PC_W-1:0]    pc_q  [NUM_ENV];
  logic [SLOT_W-1:0]  pc_slot [NUM_ENV];

  // program words: plain storage, no reset
  always_ff @(posedge clk) begin
    if (prog_we) mem_q[{prog_env, prog_slot}] <= prog_data;
  end

  // presence bits: consume on issue, operand write sets
  always_comb begin
    shd_d = shd_q;
    if (iss_valid) shd_d[{iss_env, pc_slot[iss_env]}] = 1'b0;
    if (ms_we)     shd_d[{ms_env, ms_slot}]           = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shd_q <= '0;
    else        shd_q <= shd_d;
  end

  for (genvar e = 0; e < NUM_ENV; e++) begin : g_env
    logic [PC_W-1:0] nxt;
    logic            adv;
    logic            live;

    assign pc_slot[e]     = pc_q[e][SLOT_W-1:0];
    assign live           = ~pc_q[e][PC_W-1];
    assign nxt            = pc_q[e] + PC_W'(1);
    assign adv            = iss_valid && (iss_env == ENV_W'(e));
    assign env_en[e]      = live && shd_q[{ENV_W'(e), pc_slot[e]}];
    assign env_next_en[e] = ~nxt[PC_W-1] && shd_q[{ENV_W'(e), nxt[SLOT_W-1:0]}];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pc_q[e] <= '0;
      else if (adv) pc_q[e] <= nxt;
    end

    p_pc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pc_q[e] <= PC_W'(SLOTS));
    p_end_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pc_q[e][PC_W-1] |=> $stable(pc_q[e]));
  end

  assign sel_slot  = pc_slot[sel_env];
  assign sel_instr = mem_q[{sel_env, pc_slot[sel_env]}];

  p_issue_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> env_en[iss_env]);
endmodule

// File: rtl/ens_ready.sv
module ens_ready #(
  parameter int unsigned NUM_ENV = 4,
  parameter int unsigned ENV_W   = $clog2(NUM_ENV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_we,
  input  logic [ENV_W-1:0] set_env,
  input  logic             upd_we,
  input  logic [ENV_W-1:0] upd_env,
  input  logic             upd_val,
  output logic             any,
  output logic [ENV_W-1:0] pick
);
  logic [NUM_ENV-1:0] flg_q, flg_d;

  always_comb begin
    flg_d = flg_q;
    if (upd_we) flg_d[upd_env] = upd_val;
    if (set_we) flg_d[set_env] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  // lowest index wins
  always_comb begin
    pick = '0;
    for (int i = NUM_ENV - 1; i >= 0; i--) begin
      if (flg_q[i]) pick = ENV_W'(i);
    end
  end
  assign any = |flg_q;

  p_pick_flagged_r9: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> flg_q[pick]);
  p_set_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> flg_q[$past(set_env)]);
endmodule

// File: rtl/ens_sequencer.sv
module ens_sequencer
  import ens_pkg::*;
#(
  parameter int unsigned NUM_ENV = 4,
  parameter int unsigned SLOTS   = 8,
  parameter int unsigned INSTR_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       mode_vec,
  input  logic                       prog_we,
  input  logic [$clog2(NUM_ENV)-1:0] prog_env,
  input  logic [$clog2(SLOTS)-1:0]   prog_slot,
  input  logic [INSTR_W-1:0]         prog_data,
  input  logic                       ms_we,
  input  logic [$clog2(NUM_ENV)-1:0] ms_env,
  input  logic [$clog2(SLOTS)-1:0]   ms_slot,
  output logic                       out_valid,
  input  logic                       out_ack,
  output logic [INSTR_W-1:0]         out_instr,
  output logic [$clog2(NUM_ENV)-1:0] out_env,
  output logic [$clog2(SLOTS)-1:0]   out_slot
);
  localparam int unsigned ENV_W  = $clog2(NUM_ENV);
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  seq_state_e         state_q, state_d;
  logic [ENV_W-1:0]   ptr_q, ptr_d;
  logic [ENV_W-1:0]   miss_q, miss_d;
  logic [NUM_ENV-1:0] env_en, env_next_en;
  logic [INSTR_W-1:0] sel_instr;
  logic [SLOT_W-1:0]  sel_slot;
  logic               vec_any;
  logic [ENV_W-1:0]   vec_pick;
  logic [ENV_W-1:0]   cand_env;
  logic               cand_ok, iss, vec_miss;
  logic [INSTR_W-1:0] instr_q;
  logic [ENV_W-1:0]   env_q;
  logic [SLOT_W-1:0]  slot_q;

  ens_store #(
    .NUM_ENV(NUM_ENV), .SLOTS(SLOTS), .INSTR_W(INSTR_W),
    .ENV_W(ENV_W), .SLOT_W(SLOT_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .prog_we(prog_we), .prog_env(prog_env), .prog_slot(prog_slot), .prog_data(prog_data),
    .ms_we(ms_we), .ms_env(ms_env), .ms_slot(ms_slot),
    .iss_valid(iss), .iss_env(cand_env), .sel_env(cand_env),
    .sel_instr(sel_instr), .sel_slot(sel_slot),
    .env_en(env_en), .env_next_en(env_next_en)
  );

  ens_ready #(.NUM_ENV(NUM_ENV), .ENV_W(ENV_W)) u_ready (
    .clk(clk), .rst_n(rst_n),
    .set_we(ms_we), .set_env(ms_env),
    .upd_we(iss || vec_miss), .upd_env(cand_env),
    .upd_val(iss && env_next_en[cand_env]),
    .any(vec_any), .pick(vec_pick)
  );

  assign cand_env = mode_vec ? vec_pick : ptr_q;
  assign cand_ok  = env_en[cand_env] && (vec_any || !mode_vec);
  assign iss      = (state_q == ST_SCAN) && cand_ok;
  assign vec_miss = (state_q == ST_SCAN) && mode_vec && vec_any && !env_en[cand_env];

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    miss_d  = miss_q;
    unique case (state_q)
      ST_SCAN: begin
        if (cand_ok) begin
          state_d = ST_HOLD;
          ptr_d   = cand_env + ENV_W'(1);
        end else if (mode_vec) begin
          if (!vec_any && !ms_we) state_d = ST_IDLE;
        end else begin
          ptr_d = ptr_q + ENV_W'(1);
          if (ms_we) begin
            miss_d = '0;
          end else if (miss_q == ENV_W'(NUM_ENV - 1)) begin
            miss_d  = '0;
            state_d = ST_IDLE;
          end else begin
            miss_d = miss_q + ENV_W'(1);
          end
        end
      end
      ST_HOLD: begin
        if (out_ack) begin
          state_d = ST_SCAN;
          miss_d  = '0;
        end
      end
      ST_IDLE: begin
        if (ms_we) begin
          state_d = ST_SCAN;
          miss_d  = '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SCAN;
      ptr_q   <= '0;
      miss_q  <= '0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      miss_q  <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= '0;
      env_q   <= '0;
      slot_q  <= '0;
    end else if (iss) begin
      instr_q <= sel_instr;
      env_q   <= cand_env;
      slot_q  <= sel_slot;
    end
  end

  assign out_valid = (state_q == ST_HOLD);
  assign out_instr = instr_q;
  assign out_env   = env_q;
  assign out_slot  = slot_q;

  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ack) |=> (out_valid && $stable(out_instr)
                                 && $stable(out_env) && $stable(out_slot)));
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !ms_we) |=> !out_valid);
endmodule

// File: tb/ens_sequencer_bench.sv
module ens_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int NS = 8;
  localparam int IW = 16;
  localparam int EW = $clog2(NE);
  localparam int SW = $clog2(NS);
  localparam int LIMIT = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mode_vec = 1'b0;
  logic          prog_we = 1'b0;
  logic [EW-1:0] prog_env = '0;
  logic [SW-1:0] prog_slot = '0;
  logic [IW-1:0] prog_data = '0;
  logic          ms_we = 1'b0;
  logic [EW-1:0] ms_env = '0;
  logic [SW-1:0] ms_slot = '0;
  logic          out_valid;
  logic          out_ack = 1'b0;
  logic [IW-1:0] out_instr;
  logic [EW-1:0] out_env;
  logic [SW-1:0] out_slot;

  int n_vec = 0, n_bad = 0, cyc = 0;
  int qenv[$], qslot[$];
  string qreq[$];
  bit ack_block = 1'b1, prev_valid = 1'b0;
  int hs_cyc = 0, cur_lat = 0, n_item = 0;
  int lat_log [256];

  ens_sequencer #(.NUM_ENV(NE), .SLOTS(NS), .INSTR_W(IW)) u_ens_sequencer (
    .clk(clk), .rst_n(rst_n), .mode_vec(mode_vec),
    .prog_we(prog_we), .prog_env(prog_env), .prog_slot(prog_slot), .prog_data(prog_data),
    .ms_we(ms_we), .ms_env(ms_env), .ms_slot(ms_slot),
    .out_valid(out_valid), .out_ack(out_ack),
    .out_instr(out_instr), .out_env(out_env), .out_slot(out_slot)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  function automatic logic [IW-1:0] word_of(input int e, input int s);
    return {4'hC, 4'(e), 4'(s), 4'(e) ^ 4'(s)};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (out_valid && !prev_valid) cur_lat = cyc - hs_cyc;
    prev_valid = out_valid;
    if (out_ack) begin
      out_ack = 1'b0;
    end else if (out_valid && !ack_block) begin
      if (qenv.size() == 0) begin
        check(1'b0, "R4", "unexpected issue env", int'(out_env), -1);
      end else begin
        int e, s; string r;
        e = qenv.pop_front(); s = qslot.pop_front(); r = qreq.pop_front();
        check(int'(out_env) == e, r, "issued env", int'(out_env), e);
        check(int'(out_slot) == s, r, "issued slot", int'(out_slot), s);
        check(out_instr == word_of(e, s), r, "issued word", int'(out_instr), int'(word_of(e, s)));
      end
      lat_log[n_item % 256] = cur_lat;
      n_item++;
      out_ack = 1'b1;
      hs_cyc  = cyc + 1;
    end
  end

  always @(posedge clk) begin
    if (cyc == LIMIT) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, LIMIT);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic expect_item(input int e, input int s, input string req);
    qenv.push_back(e); qslot.push_back(s); qreq.push_back(req);
  endtask

  task automatic ms_set(input int e, input int s);
    @(posedge clk); #1;
    ms_we = 1'b1; ms_env = EW'(e); ms_slot = SW'(s);
    @(posedge clk); #1;
    ms_we = 1'b0;
  endtask

  task automatic do_reset(input bit vec);
    @(posedge clk); #1;
    rst_n = 1'b0; mode_vec = vec; ack_block = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(!out_valid, "R1", "valid during reset", int'(out_valid), 0);
    rst_n = 1'b1;
    for (int e = 0; e < NE; e++) begin
      for (int s = 0; s < NS; s++) begin
        @(posedge clk); #1;
        prog_we = 1'b1; prog_env = EW'(e); prog_slot = SW'(s); prog_data = word_of(e, s);
      end
    end
    @(posedge clk); #1;
    prog_we = 1'b0;
  endtask

  task automatic wait_valid(input string req);
    int t = 0;
    while (!out_valid && t < 200) begin @(negedge clk); t++; end
    check(out_valid, req, "pending issue seen", int'(out_valid), 1);
  endtask

  task automatic drain_quiet(input string req);
    int t = 0;
    while (qenv.size() != 0 && t < 2000) begin @(negedge clk); t++; end
    check(qenv.size() == 0, req, "expected items left", qenv.size(), 0);
    repeat (15) @(negedge clk);
    check(!out_valid, "R4", "no extra issue", int'(out_valid), 0);
  endtask

  initial begin
    int base;
    logic [IW-1:0] w0; logic [EW-1:0] e0; logic [SW-1:0] s0;

    // R1: quiet with no operands
    do_reset(1'b0);
    ack_block = 1'b0;
    repeat (10) @(negedge clk);
    check(!out_valid, "R1", "valid without operands", int'(out_valid), 0);

    // R2: operand ahead of the counter waits, then in-order
    ms_set(1, 1);
    repeat (10) @(negedge clk);
    check(!out_valid, "R2", "slot ahead of counter issued", int'(out_valid), 0);
    expect_item(1, 0, "R2"); expect_item(1, 1, "R2");
    ms_set(1, 0);
    drain_quiet("R2");

    // R6: proportional round robin from the last served
    do_reset(1'b0);
    ms_set(0, 0);
    wait_valid("R6");
    ms_set(1, 0); ms_set(2, 0); ms_set(0, 1); ms_set(1, 1); ms_set(2, 1);
    expect_item(0, 0, "R6"); expect_item(1, 0, "R6"); expect_item(2, 0, "R6");
    expect_item(0, 1, "R6"); expect_item(1, 1, "R6"); expect_item(2, 1, "R6");
    @(posedge clk); #1; ack_block = 1'b0;
    drain_quiet("R6");

    // R7 latency, then R8 idle and wake
    do_reset(1'b0);
    ms_set(0, 0);
    wait_valid("R7");
    ms_set(3, 0);
    base = n_item;
    expect_item(0, 0, "R7"); expect_item(3, 0, "R7");
    @(posedge clk); #1; ack_block = 1'b0;
    drain_quiet("R7");
    check(lat_log[(base + 1) % 256] == 3, "R7", "proportional latency env0->env3",
          lat_log[(base + 1) % 256], 3);
    repeat (20) @(negedge clk);
    check(!out_valid, "R8", "idle with nothing enabled", int'(out_valid), 0);
    expect_item(2, 0, "R8");
    ms_set(2, 0);
    drain_quiet("R8");

    // R3: output held while not acknowledged
    do_reset(1'b0);
    ms_set(3, 0);
    wait_valid("R3");
    @(negedge clk);
    w0 = out_instr; e0 = out_env; s0 = out_slot;
    repeat (5) @(negedge clk);
    check(out_valid, "R3", "valid held", int'(out_valid), 1);
    check(out_instr == w0 && out_env == e0 && out_slot == s0, "R3", "payload held",
          int'(out_instr), int'(w0));
    expect_item(3, 0, "R3");
    @(posedge clk); #1; ack_block = 1'b0;
    drain_quiet("R3");

    // R5: environment runs to its end, then ignores operand writes
    do_reset(1'b0);
    ack_block = 1'b0;
    for (int s = 0; s < NS; s++) expect_item(1, s, "R5");
    for (int s = 0; s < NS; s++) ms_set(1, s);
    drain_quiet("R5");
    ms_set(1, 0); ms_set(1, 5);
    repeat (20) @(negedge clk);
    check(!out_valid, "R5", "issue after end marker", int'(out_valid), 0);

    // R9, R10: vectored priority and latency
    do_reset(1'b1);
    ms_set(2, 0);
    wait_valid("R9");
    ms_set(0, 0); ms_set(0, 1); ms_set(2, 1); ms_set(3, 0);
    base = n_item;
    expect_item(2, 0, "R10"); expect_item(0, 0, "R10"); expect_item(0, 1, "R10");
    expect_item(2, 1, "R10"); expect_item(3, 0, "R10");
    @(posedge clk); #1; ack_block = 1'b0;
    drain_quiet("R10");
    check(lat_log[(base + 1) % 256] == 1, "R9", "vectored latency first pick",
          lat_log[(base + 1) % 256], 1);
    check(lat_log[(base + 2) % 256] == 1, "R9", "vectored latency kept flag",
          lat_log[(base + 2) % 256], 1);

    // R10: flagged but not enabled drops its flag, later wakes
    ms_set(1, 2);
    repeat (20) @(negedge clk);
    check(!out_valid, "R10", "not-enabled flagged env issued", int'(out_valid), 0);
    expect_item(1, 0, "R10");
    ms_set(1, 0);
    drain_quiet("R10");
    expect_item(1, 1, "R9"); expect_item(1, 2, "R9");
    ms_set(1, 1);
    drain_quiet("R9");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule